// File: doc/BRIEF.md
# Alert Heartbeat Message Scheduler

This block decides when a platform sends status messages to an external management controller over a shared two-wire bus. While the platform sleeps, or after a watchdog lockup has been flagged, it requests a heartbeat message about every thirty seconds. The period is counted from a one-second tick. An event strobe makes it request an event message at once, ahead of any heartbeat that is due. Every new message carries a 4-bit rolling sequence number.

A bus engine outside the block does the signalling. The scheduler holds a request with the message type and sequence number until the engine reports either completion or a collision. After a collision the scheduler waits for an idle bus and offers the same message again, with the same sequence number.

Top module: `alert_hb_sched`

## Requirements
- R1: After reset, `msg_req_o` is 0, `msg_seq_o` is 0 and `msg_type_o` is 0.
- R2: While messages are enabled, the first heartbeat after the block becomes enabled, or after a message completes, is requested once `PERIOD` (default 30) ticks have been counted. Messages are enabled when `sleep_i` is 1 or the lockup flag is set. Fewer ticks produce no request. A heartbeat has `msg_type_o` = 0.
- R3: While `sleep_i` is 0 and the lockup flag is clear, no heartbeat is requested, and event strobes are ignored: no message is requested and the sequence number does not advance.
- R4: A pulse on `lockup_set_i` sets the lockup flag, and heartbeats then run with `sleep_i` at 0. A pulse on `lockup_clr_i` clears the flag and stops them. If both arrive in the same cycle, the set wins.
- R5: While messages are enabled, an event strobe causes an event message (`msg_type_o` = 1) to be requested as soon as the bus is idle. A pending event takes priority over a heartbeat that is due.
- R6: Each new message takes a sequence number 1 higher than the previous new message, modulo 16. The first message after reset carries 0, and the number wraps from 15 to 0.
- R7: When `collision_i` is 1 while the request is high, the request drops. The same type and sequence number are requested again after the bus is idle, and the sequence counter does not advance for the retry.
- R8: `msg_req_o` rises only in the cycle after `bus_idle_i` was 1. While the bus is busy, the request stays low.
- R9: Once a message has been selected, it is requested and held until `msg_done_i` or `collision_i`, even if `sleep_i` falls and the lockup flag is clear.
- R10: An event strobe that arrives while a message is in flight is held. It produces an event message after the current message completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | 1 while the platform is in a sleeping state |
| lockup_set_i | input | 1 | Pulse that sets the sticky lockup flag |
| lockup_clr_i | input | 1 | Software pulse that clears the lockup flag |
| event_i | input | 1 | Event strobe |
| tick_i | input | 1 | One-cycle pulse once per second |
| bus_idle_i | input | 1 | 1 when the shared bus is idle |
| collision_i | input | 1 | Arbitration lost during the current message |
| msg_done_i | input | 1 | Current message sent successfully |
| msg_req_o | output | 1 | Message request to the bus engine |
| msg_type_o | output | 1 | 0 = heartbeat, 1 = event |
| msg_seq_o | output | 4 | Sequence number of the requested message |

## Verification
Several faults show at the ports on the cycle of the first request that follows them:
- A wrong period count moves that request away from the tick that should trigger it.
- A lost pending event drops an event message that should follow the current one.
- A sequence register advanced on a retry shows a changed number on the re-request.

A wrong transmit state holds the request high over a busy bus, or leaves it low after the bus has become idle, within two cycles. The bench model compares all three outputs on every clock, so a divergence is reported in the cycle it appears.

// File: rtl/alert_hb_pkg.sv
package alert_hb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} tx_state_e;
  typedef enum logic {MSG_HB = 1'b0, MSG_EVT = 1'b1} msg_type_e;
endpackage

// File: rtl/alert_hb_timer.sv
module alert_hb_timer #(
  parameter int PERIOD = 30,
  localparam int CW = $clog2(PERIOD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic reload_i,
  output logic due_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= CW'(PERIOD);
    else if (!en_i || reload_i)        cnt_q <= CW'(PERIOD);
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign due_o = en_i && (cnt_q == '0);

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(PERIOD));
  // R2
  reload_clears_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> !due_o);
endmodule

// File: rtl/alert_tx_ctrl.sv
module alert_tx_ctrl
  import alert_hb_pkg::*;
#(
  parameter int SEQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hb_due_i,
  input  logic             ev_i,
  input  logic             bus_idle_i,
  input  logic             collision_i,
  input  logic             done_i,
  output logic             req_o,
  output logic             type_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             reload_o
);
  tx_state_e        st_q, st_d;
  msg_type_e        type_q;
  logic [SEQ_W-1:0] seq_next_q, seq_q;
  logic             pend_q, ev_any, launch;

  assign ev_any   = pend_q | ev_i;
  assign launch   = (st_q == ST_IDLE) && (ev_any || hb_due_i);
  assign reload_o = (st_q == ST_SEND) && done_i && !collision_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (launch) st_d = ST_WAIT;
      ST_WAIT: if (bus_idle_i) st_d = ST_SEND;
      ST_SEND: if (collision_i) st_d = ST_WAIT;
               else if (done_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      type_q     <= MSG_HB;
      seq_q      <= '0;
      seq_next_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      // pending event is consumed only by a launch from idle
      pend_q <= ((st_q == ST_IDLE) && ev_any) ? 1'b0 : ev_any;
      if (launch) begin
        type_q     <= ev_any ? MSG_EVT : MSG_HB;
        seq_q      <= seq_next_q;
        seq_next_q <= seq_next_q + 1'b1;
      end
    end
  end

  assign req_o  = (st_q == ST_SEND);
  assign type_o = type_q;
  assign seq_o  = seq_q;

  // R8
  req_needs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(bus_idle_i));
  // R7
  collision_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && collision_i) |=> (!req_o && $stable(seq_o) && $stable(type_o)));
  // R6
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_o != $past(seq_o)) |-> (seq_o == SEQ_W'($past(seq_o) + 1'b1)));
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !done_i && !collision_i) |=> req_o);
endmodule

// File: rtl/alert_hb_sched.sv
module alert_hb_sched #(
  parameter int PERIOD = 30,
  parameter int SEQ_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             lockup_set_i,
  input  logic             lockup_clr_i,
  input  logic             event_i,
  input  logic             tick_i,
  input  logic             bus_idle_i,
  input  logic             collision_i,
  input  logic             msg_done_i,
  output logic             msg_req_o,
  output logic             msg_type_o,
  output logic [SEQ_W-1:0] msg_seq_o
);
  logic lock_q, hb_en, hb_due, reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           lock_q <= 1'b0;
    else if (lockup_set_i) lock_q <= 1'b1;
    else if (lockup_clr_i) lock_q <= 1'b0;
  end

  assign hb_en = sleep_i | lock_q;

  alert_hb_timer #(.PERIOD(PERIOD)) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (hb_en),
    .tick_i   (tick_i),
    .reload_i (reload),
    .due_o    (hb_due)
  );

  alert_tx_ctrl #(.SEQ_W(SEQ_W)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hb_due_i    (hb_due),
    .ev_i        (event_i & hb_en),
    .bus_idle_i  (bus_idle_i),
    .collision_i (collision_i),
    .done_i      (msg_done_i),
    .req_o       (msg_req_o),
    .type_o      (msg_type_o),
    .seq_o       (msg_seq_o),
    .reload_o    (reload)
  );

  // R4
  lock_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockup_set_i |=> lock_q);
endmodule

// File: tb/alert_hb_sched_tb_top.sv
`timescale 1ns/1ps
module alert_hb_sched_tb_top;
  localparam int PERIOD = 30;

  logic clk_i = 0, rst_ni = 0;
  logic sleep_i = 0, lockup_set_i = 0, lockup_clr_i = 0, event_i = 0, tick_i = 0;
  logic bus_idle_i = 1, collision_i = 0, msg_done_i = 0;
  logic msg_req_o, msg_type_o;
  logic [3:0] msg_seq_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  alert_hb_sched #(.PERIOD(PERIOD), .SEQ_W(4)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: idle=0 wait=1 send=2
  int m_st, m_cnt, m_nseq, m_seq, m_type;
  bit m_pend, m_lock;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = PERIOD; m_nseq = 0; m_seq = 0; m_type = 0;
      m_pend = 0; m_lock = 0;
    end else begin
      bit en, evany, due, fin;
      int st, cnt;
      en    = sleep_i || m_lock;
      evany = m_pend || (event_i && en);
      due   = en && (m_cnt == 0);
      fin   = (m_st == 2) && msg_done_i && !collision_i;
      cnt = m_cnt;
      if (!en || fin) cnt = PERIOD;
      else if (tick_i && cnt > 0) cnt = cnt - 1;
      st = m_st;
      if (m_st == 0 && (evany || due)) begin
        st = 1; m_type = evany ? 1 : 0; m_seq = m_nseq; m_nseq = (m_nseq + 1) % 16;
      end else if (m_st == 1 && bus_idle_i) st = 2;
      else if (m_st == 2 && collision_i) st = 1;
      else if (m_st == 2 && msg_done_i) st = 0;
      m_pend = (m_st == 0 && evany) ? 0 : evany;
      if (lockup_set_i) m_lock = 1; else if (lockup_clr_i) m_lock = 0;
      m_st = st; m_cnt = cnt;
    end
  end

  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !finished) begin
      chk(msg_req_o == (m_st == 2), "R2/R5/R8 model req", msg_req_o, m_st == 2);
      chk(msg_seq_o == m_seq[3:0], "R6 model seq", msg_seq_o, m_seq);
      chk(msg_type_o == m_type[0], "R5 model type", msg_type_o, m_type);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) tick_i = 1;
      @(negedge clk_i) tick_i = 0;
    end
  endtask
  task automatic pulse_event();
    @(negedge clk_i) event_i = 1;
    @(negedge clk_i) event_i = 0;
  endtask
  task automatic wait_req(input int n, output bit got);
    got = 0;
    for (int i = 0; i < n && !got; i++) begin
      @(posedge clk_i); #1;
      if (msg_req_o) got = 1;
    end
  endtask
  task automatic finish_msg();
    @(negedge clk_i) msg_done_i = 1;
    @(negedge clk_i) msg_done_i = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    chk(0, "watchdog", 0, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit got;
    int seen;
    cyc(3);
    @(posedge clk_i); #1;
    // R1
    chk(!msg_req_o && msg_seq_o == 0 && !msg_type_o, "R1 reset state", msg_req_o, 0);
    @(negedge clk_i) rst_ni = 1;

    // R2 sleep heartbeat
    @(negedge clk_i) sleep_i = 1;
    ticks(PERIOD - 1);
    wait_req(4, got);
    chk(!got, "R2 no early heartbeat", got, 0);
    ticks(1);
    wait_req(4, got);
    chk(got && msg_type_o == 0 && msg_seq_o == 0, "R2 heartbeat seq0", msg_seq_o, 0);
    finish_msg();
    ticks(PERIOD - 1);
    wait_req(4, got);
    chk(!got, "R2 reload after send", got, 0);
    ticks(1);
    wait_req(4, got);
    chk(got && msg_seq_o == 1, "R2 second heartbeat", msg_seq_o, 1);
    finish_msg();

    // R3 awake, no lock
    @(negedge clk_i) sleep_i = 0;
    pulse_event();
    ticks(PERIOD + 10);
    pulse_event();
    wait_req(4, got);
    chk(!got, "R3 awake silent", got, 0);

    // R4 lockup flag
    @(negedge clk_i) lockup_set_i = 1; lockup_clr_i = 1;
    @(negedge clk_i) lockup_set_i = 0; lockup_clr_i = 0;
    ticks(PERIOD);
    wait_req(4, got);
    chk(got && msg_type_o == 0 && msg_seq_o == 2, "R4 lock heartbeat (R3 no seq skip)", msg_seq_o, 2);
    finish_msg();
    @(negedge clk_i) lockup_clr_i = 1;
    @(negedge clk_i) lockup_clr_i = 0;
    ticks(PERIOD + 5);
    wait_req(4, got);
    chk(!got, "R4 cleared silent", got, 0);

    // R5 event
    @(negedge clk_i) sleep_i = 1;
    pulse_event();
    wait_req(3, got);
    chk(got && msg_type_o == 1 && msg_seq_o == 3, "R5 event immediate", msg_seq_o, 3);

    // R7/R8 collision then busy bus
    @(negedge clk_i) collision_i = 1; bus_idle_i = 0;
    @(negedge clk_i) collision_i = 0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk_i); #1;
      if (msg_req_o) seen++;
    end
    chk(seen == 0, "R8 no request on busy bus", seen, 0);
    @(negedge clk_i) bus_idle_i = 1;
    wait_req(3, got);
    chk(got && msg_seq_o == 3 && msg_type_o == 1, "R7 retry same message", msg_seq_o, 3);
    finish_msg();

    // R9 completion across wake
    @(negedge clk_i) bus_idle_i = 0;
    pulse_event();
    cyc(2);
    @(negedge clk_i) sleep_i = 0; bus_idle_i = 1;
    wait_req(3, got);
    chk(got && msg_seq_o == 4, "R9 selected message still sent (R7 no skip)", msg_seq_o, 4);
    cyc(3);
    @(posedge clk_i); #1;
    chk(msg_req_o, "R9 request held while awake", msg_req_o, 1);
    finish_msg();

    // R10 event during flight
    @(negedge clk_i) sleep_i = 1;
    pulse_event();
    wait_req(3, got);
    chk(got && msg_seq_o == 5, "R10 first event", msg_seq_o, 5);
    pulse_event();
    finish_msg();
    wait_req(4, got);
    chk(got && msg_type_o == 1 && msg_seq_o == 6, "R10 held event sent", msg_seq_o, 6);
    finish_msg();

    // R6 wrap
    for (int s = 7; s <= 17; s++) begin
      pulse_event();
      wait_req(3, got);
      chk(got && msg_seq_o == 4'(s), "R6 sequence wrap", msg_seq_o, s % 16);
      finish_msg();
    end

    cyc(4);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule